// File: doc/BRIEF.md
# Forwarding Drop and Abort Handler

This block sits on the forwarding path of a link tunnel. It looks at a packet that is routed toward the far link, and at the control state of the far transmitter that packet would leave through. In the same cycle it returns one of three decisions. The packet is sent, held in its queue, or dropped for good. A drop happens only for a small set of conditions the transmitter cannot recover from. Every other reason the transmitter cannot send is treated as temporary, and the packet is held.

A dropped packet is then sorted by type, and one of three actions follows. Broadcasts, and interrupt or system messages that carry a silent flag, disappear with no trace. Any other posted request or response sets a sticky end-of-chain error bit for that transmitter. Two global enables route those bits to a fatal or a nonfatal interrupt line. A dropped nonposted request raises a one-cycle strobe that asks a separate response builder for a master-abort reply. The strobe carries the request's tag and source ID. Building the response packet is not part of this block.

Top module: `fwd_drop_handler`

## Requirements
- R1: When `pkt_valid` is high and the selected transmitter's `tx_eoc_ctl` bit is set, `fwd_drop` is 1 and `drop_cause` is 1, whatever the other control bits are.
- R2: With that bit clear, a set `drop_uninit` and a clear `tx_init_done` bit for the selected transmitter give `fwd_drop`=1 and `drop_cause`=2.
- R3: With neither condition above present, a packet that is not a response (`pkt_kind` not 2) and has `pkt_ext_addr` set is dropped with `drop_cause`=3 if the selected transmitter's `tx_addr64_en` is clear. A response is never dropped for address width.
- R4: With no drop cause, `fwd_accept` follows the selected `tx_ready` bit and `fwd_hold` is its inverse. When `pkt_valid` is high, exactly one of accept, drop and hold is set. When it is low, none of them is set and `drop_cause` is 0. All of this happens in the same cycle as the inputs.
- R5: A dropped packet with `pkt_kind`=3 (broadcast), or with `pkt_is_msg` and `pkt_silent` both set, sets no error bit and raises no response strobe.
- R6: Any other dropped posted request (`pkt_kind`=0) or response (`pkt_kind`=2) sets `eoc_err[pkt_tx_sel]` at the next clock edge. The bit stays set until an `err_clr` bit is seen at an edge, and a set in the same cycle wins over a clear.
- R7: Any other dropped nonposted request (`pkt_kind`=1) pulses `rsp_valid` for one cycle after the next edge, with `rsp_tag` and `rsp_srcid` equal to the request's `pkt_tag` and `pkt_srcid`. Accepted or held packets never raise the strobe.
- R8: After each edge, `irq_fatal` equals `fatal_en` ANDed with the OR of the error bits just loaded. `irq_nonfatal` equals `nonfatal_en` ANDed with the same OR.
- R9: A synchronous active-high `rst` clears the error bits, both interrupt lines and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Descriptor present this cycle |
| pkt_tx_sel | input | SEL_W | Index of the far transmitter |
| pkt_kind | input | 2 | 0 posted request, 1 nonposted request, 2 response, 3 broadcast |
| pkt_is_msg | input | 1 | Packet is an interrupt or system message |
| pkt_silent | input | 1 | Silent-drop flag of a message |
| pkt_ext_addr | input | 1 | Request carries a 64-bit address |
| pkt_tag | input | TAG_W | Request tag |
| pkt_srcid | input | SRCID_W | Request source ID |
| tx_ready | input | NUM_TX | Transmitter can send now |
| tx_eoc_ctl | input | NUM_TX | Transmitter forced to end-of-chain |
| tx_init_done | input | NUM_TX | Transmitter link initialized |
| tx_addr64_en | input | NUM_TX | Transmitter accepts 64-bit addresses |
| drop_uninit | input | 1 | Global: drop toward uninitialized links |
| fatal_en | input | 1 | Route error bits to the fatal interrupt |
| nonfatal_en | input | 1 | Route error bits to the nonfatal interrupt |
| err_clr | input | NUM_TX | Clear error bits |
| fwd_accept | output | 1 | Send the packet now |
| fwd_drop | output | 1 | Drop the packet |
| fwd_hold | output | 1 | Keep the packet queued |
| drop_cause | output | 2 | 0 none, 1 end-of-chain, 2 uninitialized, 3 address width |
| eoc_err | output | NUM_TX | Sticky end-of-chain error bits |
| irq_fatal | output | 1 | Fatal interrupt |
| irq_nonfatal | output | 1 | Nonfatal interrupt |
| rsp_valid | output | 1 | Master-abort response request |
| rsp_tag | output | TAG_W | Tag for the response |
| rsp_srcid | output | SRCID_W | Source ID for the response |

## Verification
The bench builds the block with three transmitters, so the index is two bits wide and not every index value names a real transmitter. Only valid indices are driven. It also uses a six-bit tag and a four-bit source ID, which differ from the defaults, so any mix-up between the two response fields would show. With three transmitters, error bits can collect on several links at once while others are being cleared. The interrupt OR can then be seen to drop only when every bit is gone.

// File: rtl/fdh_pkg.sv
package fdh_pkg;

  typedef enum logic [1:0] {
    PK_POSTED    = 2'd0,
    PK_NONPOSTED = 2'd1,
    PK_RESPONSE  = 2'd2,
    PK_BCAST     = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    DC_NONE   = 2'd0,
    DC_EOC    = 2'd1,
    DC_UNINIT = 2'd2,
    DC_ADDR   = 2'd3
  } drop_cause_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_SILENT = 2'd1,
    ACT_LOG    = 2'd2,
    ACT_ABORT  = 2'd3
  } drop_act_e;

endpackage

// File: rtl/fdh_drop_eval.sv
module fdh_drop_eval
  import fdh_pkg::*;
#(
  parameter int NUM_TX = 2,
  parameter int SEL_W  = 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        kind,
  input  logic              ext_addr,
  input  logic              drop_uninit,
  input  logic [NUM_TX-1:0] tx_ready,
  input  logic [NUM_TX-1:0] tx_eoc_ctl,
  input  logic [NUM_TX-1:0] tx_init_done,
  input  logic [NUM_TX-1:0] tx_addr64_en,
  output drop_cause_e       cause,
  output logic              can_send
);

  drop_cause_e cause_v [NUM_TX];
  logic        addr_chk;
  logic        sel_ok;

  // responses carry no address, so the width check applies to requests only
  assign addr_chk = ext_addr && (kind != PK_RESPONSE);

  // fixed priority per transmitter: end-of-chain, uninitialized, address width
  for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
    assign cause_v[g] = tx_eoc_ctl[g]                   ? DC_EOC    :
                        (drop_uninit && !tx_init_done[g]) ? DC_UNINIT :
                        (addr_chk && !tx_addr64_en[g])    ? DC_ADDR   :
                                                            DC_NONE;
  end

  assign sel_ok   = (int'(sel) < NUM_TX);
  assign cause    = sel_ok ? cause_v[sel] : DC_NONE;
  assign can_send = sel_ok && tx_ready[sel];

endmodule

// File: rtl/fdh_action.sv
module fdh_action
  import fdh_pkg::*;
(
  input  logic       dropped,
  input  logic [1:0] kind,
  input  logic       is_msg,
  input  logic       silent,
  output drop_act_e  act
);

  always_comb begin
    if (!dropped)
      act = ACT_NONE;
    else if ((kind == PK_BCAST) || (is_msg && silent))
      act = ACT_SILENT;
    else if (kind == PK_NONPOSTED)
      act = ACT_ABORT;
    else
      act = ACT_LOG;
  end

endmodule

// File: rtl/fdh_err_log.sv
module fdh_err_log #(
  parameter int NUM_TX = 2,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_en,
  input  logic [SEL_W-1:0]  log_sel,
  input  logic [NUM_TX-1:0] err_clr,
  input  logic              fatal_en,
  input  logic              nonfatal_en,
  output logic [NUM_TX-1:0] err_q,
  output logic              irq_fatal,
  output logic              irq_nonfatal
);

  logic [NUM_TX-1:0] set_v;
  logic [NUM_TX-1:0] err_nxt;
  logic              any_nxt;

  for (genvar g = 0; g < NUM_TX; g++) begin : g_set
    assign set_v[g] = log_en && (int'(log_sel) == g);
  end

  // a new event outranks a clear seen in the same cycle
  assign err_nxt = (err_q & ~err_clr) | set_v;
  assign any_nxt = |err_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q        <= '0;
      irq_fatal    <= 1'b0;
      irq_nonfatal <= 1'b0;
    end else begin
      err_q        <= err_nxt;
      irq_fatal    <= fatal_en && any_nxt;
      irq_nonfatal <= nonfatal_en && any_nxt;
    end
  end

endmodule

// File: rtl/fwd_drop_handler.sv
module fwd_drop_handler
  import fdh_pkg::*;
#(
  parameter int NUM_TX  = 2,
  parameter int TAG_W   = 5,
  parameter int SRCID_W = 5,
  localparam int SEL_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_valid,
  input  logic [SEL_W-1:0]   pkt_tx_sel,
  input  logic [1:0]         pkt_kind,
  input  logic               pkt_is_msg,
  input  logic               pkt_silent,
  input  logic               pkt_ext_addr,
  input  logic [TAG_W-1:0]   pkt_tag,
  input  logic [SRCID_W-1:0] pkt_srcid,
  input  logic [NUM_TX-1:0]  tx_ready,
  input  logic [NUM_TX-1:0]  tx_eoc_ctl,
  input  logic [NUM_TX-1:0]  tx_init_done,
  input  logic [NUM_TX-1:0]  tx_addr64_en,
  input  logic               drop_uninit,
  input  logic               fatal_en,
  input  logic               nonfatal_en,
  input  logic [NUM_TX-1:0]  err_clr,
  output logic               fwd_accept,
  output logic               fwd_drop,
  output logic               fwd_hold,
  output logic [1:0]         drop_cause,
  output logic [NUM_TX-1:0]  eoc_err,
  output logic               irq_fatal,
  output logic               irq_nonfatal,
  output logic               rsp_valid,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic [SRCID_W-1:0] rsp_srcid
);

  drop_cause_e cause_raw;
  logic        can_send;
  logic        dropped;
  drop_act_e   act;

  fdh_drop_eval #(
    .NUM_TX (NUM_TX),
    .SEL_W  (SEL_W)
  ) u_eval (
    .sel          (pkt_tx_sel),
    .kind         (pkt_kind),
    .ext_addr     (pkt_ext_addr),
    .drop_uninit  (drop_uninit),
    .tx_ready     (tx_ready),
    .tx_eoc_ctl   (tx_eoc_ctl),
    .tx_init_done (tx_init_done),
    .tx_addr64_en (tx_addr64_en),
    .cause        (cause_raw),
    .can_send     (can_send)
  );

  // the decision is combinational so the queue can act on it in the same cycle
  assign dropped    = pkt_valid && (cause_raw != DC_NONE);
  assign fwd_drop   = dropped;
  assign fwd_accept = pkt_valid && (cause_raw == DC_NONE) && can_send;
  assign fwd_hold   = pkt_valid && (cause_raw == DC_NONE) && !can_send;
  assign drop_cause = pkt_valid ? cause_raw : DC_NONE;

  fdh_action u_act (
    .dropped (dropped),
    .kind    (pkt_kind),
    .is_msg  (pkt_is_msg),
    .silent  (pkt_silent),
    .act     (act)
  );

  fdh_err_log #(
    .NUM_TX (NUM_TX),
    .SEL_W  (SEL_W)
  ) u_log (
    .clk          (clk),
    .rst          (rst),
    .log_en       (act == ACT_LOG),
    .log_sel      (pkt_tx_sel),
    .err_clr      (err_clr),
    .fatal_en     (fatal_en),
    .nonfatal_en  (nonfatal_en),
    .err_q        (eoc_err),
    .irq_fatal    (irq_fatal),
    .irq_nonfatal (irq_nonfatal)
  );

  // abort request toward the response builder; fields load only on a strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_srcid <= '0;
    end else begin
      rsp_valid <= (act == ACT_ABORT);
      if (act == ACT_ABORT) begin
        rsp_tag   <= pkt_tag;
        rsp_srcid <= pkt_srcid;
      end
    end
  end

endmodule

// File: rtl/fdh_checker.sv
module fdh_checker #(
  parameter int NUM_TX  = 2,
  parameter int TAG_W   = 5,
  parameter int SRCID_W = 5,
  localparam int SEL_W  = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               pkt_valid,
  input logic [SEL_W-1:0]   pkt_tx_sel,
  input logic [1:0]         pkt_kind,
  input logic               pkt_is_msg,
  input logic               pkt_silent,
  input logic [TAG_W-1:0]   pkt_tag,
  input logic [NUM_TX-1:0]  tx_eoc_ctl,
  input logic [NUM_TX-1:0]  err_clr,
  input logic               fwd_accept,
  input logic               fwd_drop,
  input logic               fwd_hold,
  input logic [1:0]         drop_cause,
  input logic [NUM_TX-1:0]  eoc_err,
  input logic               irq_fatal,
  input logic               irq_nonfatal,
  input logic               rsp_valid,
  input logic [TAG_W-1:0]   rsp_tag
);

  logic silent_cls;
  assign silent_cls = (pkt_kind == 2'd3) || (pkt_is_msg && pkt_silent);

  p_one_decision_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> ($countones({fwd_accept, fwd_drop, fwd_hold}) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> (!fwd_accept && !fwd_drop && !fwd_hold && drop_cause == 2'd0));

  p_eoc_first_r1: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (int'(pkt_tx_sel) < NUM_TX) && tx_eoc_ctl[pkt_tx_sel])
      |-> (fwd_drop && drop_cause == 2'd1));

  p_abort_tag_r7: assert property (@(posedge clk) disable iff (rst)
    (fwd_drop && pkt_kind == 2'd1 && !silent_cls)
      |=> (rsp_valid && rsp_tag == $past(pkt_tag)));

  p_silent_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (fwd_drop && silent_cls) |=> (!rsp_valid && ((eoc_err & ~$past(eoc_err)) == '0)));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(eoc_err) & ~$past(err_clr) & ~eoc_err) == '0));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_fatal || irq_nonfatal) |-> (eoc_err != '0));

endmodule

bind fwd_drop_handler fdh_checker #(
  .NUM_TX  (NUM_TX),
  .TAG_W   (TAG_W),
  .SRCID_W (SRCID_W)
) u_fdh_chk (
  .clk          (clk),
  .rst          (rst),
  .pkt_valid    (pkt_valid),
  .pkt_tx_sel   (pkt_tx_sel),
  .pkt_kind     (pkt_kind),
  .pkt_is_msg   (pkt_is_msg),
  .pkt_silent   (pkt_silent),
  .pkt_tag      (pkt_tag),
  .tx_eoc_ctl   (tx_eoc_ctl),
  .err_clr      (err_clr),
  .fwd_accept   (fwd_accept),
  .fwd_drop     (fwd_drop),
  .fwd_hold     (fwd_hold),
  .drop_cause   (drop_cause),
  .eoc_err      (eoc_err),
  .irq_fatal    (irq_fatal),
  .irq_nonfatal (irq_nonfatal),
  .rsp_valid    (rsp_valid),
  .rsp_tag      (rsp_tag)
);

// File: tb/fwd_drop_handler_test.sv
module fwd_drop_handler_test;

  localparam int NT  = 3;
  localparam int TW  = 6;
  localparam int SW  = 4;
  localparam int SLW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pkt_valid = 1'b0;
  logic [SLW-1:0] pkt_tx_sel = '0;
  logic [1:0]    pkt_kind = '0;
  logic          pkt_is_msg = 1'b0, pkt_silent = 1'b0, pkt_ext_addr = 1'b0;
  logic [TW-1:0] pkt_tag = '0;
  logic [SW-1:0] pkt_srcid = '0;
  logic [NT-1:0] tx_ready = '0, tx_eoc_ctl = '0, tx_init_done = '0, tx_addr64_en = '0;
  logic          drop_uninit = 1'b0, fatal_en = 1'b0, nonfatal_en = 1'b0;
  logic [NT-1:0] err_clr = '0;
  logic          fwd_accept, fwd_drop, fwd_hold;
  logic [1:0]    drop_cause;
  logic [NT-1:0] eoc_err;
  logic          irq_fatal, irq_nonfatal, rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [SW-1:0] rsp_srcid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected registered state
  logic [NT-1:0] m_err = '0;
  logic          m_irqf = 1'b0, m_irqn = 1'b0, m_rsp = 1'b0;
  logic [TW-1:0] m_tag = '0;
  logic [SW-1:0] m_src = '0;
  string         m_rsp_req = "R7";

  always #10 clk = ~clk;

  fwd_drop_handler #(.NUM_TX(NT), .TAG_W(TW), .SRCID_W(SW)) uut (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_tx_sel(pkt_tx_sel),
    .pkt_kind(pkt_kind), .pkt_is_msg(pkt_is_msg), .pkt_silent(pkt_silent),
    .pkt_ext_addr(pkt_ext_addr), .pkt_tag(pkt_tag), .pkt_srcid(pkt_srcid),
    .tx_ready(tx_ready), .tx_eoc_ctl(tx_eoc_ctl), .tx_init_done(tx_init_done),
    .tx_addr64_en(tx_addr64_en), .drop_uninit(drop_uninit), .fatal_en(fatal_en),
    .nonfatal_en(nonfatal_en), .err_clr(err_clr), .fwd_accept(fwd_accept),
    .fwd_drop(fwd_drop), .fwd_hold(fwd_hold), .drop_cause(drop_cause),
    .eoc_err(eoc_err), .irq_fatal(irq_fatal), .irq_nonfatal(irq_nonfatal),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_srcid(rsp_srcid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cause();
    if (!pkt_valid) return 0;
    if (tx_eoc_ctl[pkt_tx_sel]) return 1;
    if (drop_uninit && !tx_init_done[pkt_tx_sel]) return 2;
    if (pkt_kind != 2'd2 && pkt_ext_addr && !tx_addr64_en[pkt_tx_sel]) return 3;
    return 0;
  endfunction

  function automatic string cause_req(input int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // called right after a falling edge with inputs driven
  task automatic step();
    int c;
    logic [2:0] dec, edec;
    bit drop, silent;
    logic [NT-1:0] nerr;
    #1;
    c = exp_cause();
    drop = pkt_valid && c != 0;
    edec = {pkt_valid && c == 0 && tx_ready[pkt_tx_sel], drop,
            pkt_valid && c == 0 && !tx_ready[pkt_tx_sel]};
    dec  = {fwd_accept, fwd_drop, fwd_hold};
    chk(dec == edec && drop_cause == 2'(c), cause_req(c), "decision/cause",
        {dec, drop_cause}, {edec, 2'(c)});
    silent = (pkt_kind == 2'd3) || (pkt_is_msg && pkt_silent);
    nerr = m_err & ~err_clr;
    if (drop && !silent && pkt_kind != 2'd1) nerr[pkt_tx_sel] = 1'b1;
    m_rsp = drop && !silent && pkt_kind == 2'd1;
    m_rsp_req = (drop && silent) ? "R5" : "R7";
    if (m_rsp) begin m_tag = pkt_tag; m_src = pkt_srcid; end
    m_err  = nerr;
    m_irqf = fatal_en && (nerr != '0);
    m_irqn = nonfatal_en && (nerr != '0);
    @(negedge clk);
    chk(eoc_err == m_err, (drop && silent) ? "R5" : "R6", "eoc_err",
        int'(eoc_err), int'(m_err));
    chk(rsp_valid == m_rsp, m_rsp_req, "rsp_valid", int'(rsp_valid), int'(m_rsp));
    if (m_rsp)
      chk(rsp_tag == m_tag && rsp_srcid == m_src, "R7", "rsp tag/srcid",
          {rsp_tag, rsp_srcid}, {m_tag, m_src});
    chk(irq_fatal == m_irqf && irq_nonfatal == m_irqn, "R8", "irq pair",
        {irq_fatal, irq_nonfatal}, {m_irqf, m_irqn});
  endtask

  task automatic clear_pkt();
    pkt_valid = 1'b0; pkt_kind = 2'd0; pkt_is_msg = 1'b0; pkt_silent = 1'b0;
    pkt_ext_addr = 1'b0; tx_eoc_ctl = '0; tx_init_done = '1; tx_addr64_en = '1;
    tx_ready = '1; drop_uninit = 1'b0; err_clr = '0;
  endtask

  initial begin
    void'($urandom(32'h1F3A_55C1));
    fatal_en = 1'b1; nonfatal_en = 1'b1; err_clr = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(eoc_err == '0 && !irq_fatal && !irq_nonfatal && !rsp_valid, "R9",
        "reset state", {eoc_err, irq_fatal, irq_nonfatal, rsp_valid}, 0);
    clear_pkt();
    @(negedge clk);

    // R1: end-of-chain outranks the other two conditions
    pkt_valid = 1'b1; pkt_tx_sel = 2'd2; pkt_kind = 2'd0; pkt_ext_addr = 1'b1;
    tx_eoc_ctl = 3'b100; tx_init_done = 3'b000; tx_addr64_en = 3'b000; drop_uninit = 1'b1;
    step();
    // R3: response with a wide address is not dropped; R4 hold when not ready
    clear_pkt(); pkt_valid = 1'b1; pkt_kind = 2'd2; pkt_ext_addr = 1'b1;
    tx_addr64_en = '0; tx_ready = '0; pkt_tx_sel = 2'd1;
    step();
    // R6: set and clear of the same bit in one cycle, set wins
    clear_pkt(); pkt_valid = 1'b1; pkt_kind = 2'd0; pkt_tx_sel = 2'd2;
    tx_eoc_ctl = 3'b100; err_clr = 3'b100;
    step();
    // R5: silent nonposted message raises no strobe
    clear_pkt(); pkt_valid = 1'b1; pkt_kind = 2'd1; pkt_is_msg = 1'b1;
    pkt_silent = 1'b1; tx_eoc_ctl = '1; pkt_tx_sel = 2'd0;
    step();
    // R7: nonposted drop for address width
    clear_pkt(); pkt_valid = 1'b1; pkt_kind = 2'd1; pkt_ext_addr = 1'b1;
    tx_addr64_en = 3'b101; pkt_tx_sel = 2'd1; pkt_tag = 6'h2B; pkt_srcid = 4'h9;
    step();
    // R8: clear everything, interrupts fall
    clear_pkt(); err_clr = '1;
    step();

    for (int i = 0; i < 3000; i++) begin
      pkt_valid    = ($urandom_range(7, 0) != 0);
      pkt_tx_sel   = SLW'($urandom_range(NT - 1, 0));
      pkt_kind     = 2'($urandom_range(3, 0));
      pkt_is_msg   = $urandom_range(1, 0) == 1;
      pkt_silent   = $urandom_range(1, 0) == 1;
      pkt_ext_addr = $urandom_range(1, 0) == 1;
      pkt_tag      = TW'($urandom);
      pkt_srcid    = SW'($urandom);
      for (int t = 0; t < NT; t++) begin
        tx_ready[t]     = $urandom_range(1, 0) == 1;
        tx_eoc_ctl[t]   = $urandom_range(5, 0) == 0;
        tx_init_done[t] = $urandom_range(3, 0) != 0;
        tx_addr64_en[t] = $urandom_range(2, 0) != 0;
        err_clr[t]      = $urandom_range(11, 0) == 0;
      end
      drop_uninit = $urandom_range(1, 0) == 1;
      fatal_en    = $urandom_range(3, 0) != 0;
      nonfatal_en = $urandom_range(1, 0) == 1;
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule